// File: doc/BRIEF.md
# Pseudo-Random Noise Channel

This block is the fourth voice of a square-wave sound generator. A down-counter, paced by a shared prescaled tick, runs at one of three fixed rates or follows the period currently programmed into tone voice 2. Each time the counter expires it reloads and flips an internal half-period bit. On every rising edge of that bit a shift register steps one place to the right. The bit that falls out of the low end becomes the channel's one-bit output, ready for a separate attenuator and mixer.

A three-bit control value chooses the rate and the mode. In white mode the new top bit is the parity of the register masked by a tap pattern, so the width and the tap mask are parameters and other register variants can be modelled. In the alternative mode the low bit simply wraps around to the top. Because every control write reseeds the register with a single set top bit, the wrapping mode gives a short pulse once per register length. It is a narrow duty-cycle divider, not noise. Attenuation and mixing sit outside the block.

Top module: `psg_noise_chan`

## Requirements
- R1: After reset, noiseOut is 0, the control value is 0, the rate counter is 0, the half-period bit is 0, and the shift register holds only its top bit set.
- R2: Control bits [1:0] pick the counter reload value: 0 gives 16, 1 gives 32, 2 gives 64, and 3 gives tone2Period. The reload uses the control value that was registered before the current cycle.
- R3: On a cycle with tick high, the counter steps down by one if it is non-zero. If the result is zero, the counter reloads and the half-period bit flips. On a cycle with tick low and ctrlWr low, nothing changes and noiseOut holds.
- R4: The register shifts one place only on an expiry that flips the half-period bit from 0 to 1. The register therefore shifts once per two expiries.
- R5: On a shift, noiseOut takes the old bit 0 of the register one clock later. Between shifts, noiseOut holds.
- R6: With control bit 2 = 1 (white), the new top bit is the parity of the register ANDed with TAP_MASK. The default is 16 bits with taps at bits 0 and 3.
- R7: With control bit 2 = 0, the old bit 0 becomes the new top bit. Starting from the seed, noiseOut then goes high for one shift in every LFSR_W shifts.
- R8: A ctrlWr pulse loads the register with only its top bit set. If a shift falls in the same cycle, the reseed wins and noiseOut holds.
- R9: A ctrlWr pulse leaves the counter and the half-period bit untouched. The new rate applies from the next reload.
- R10: In rate 3, a tone2Period of 0 or 1 makes the counter expire on every tick, so the register shifts on every second tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrlVal | input | 3 | Control value: [2] mode, [1:0] rate |
| ctrlWr | input | 1 | Control write strobe; also reseeds the register |
| tick | input | 1 | Prescaled generator tick |
| tone2Period | input | PERIOD_W | Current period of tone voice 2 |
| noiseOut | output | 1 | Bit shifted out of the register |

## Verification
A control write and a shift can fall in the same clock: the reseed must win, and the output must keep its old value. The bench provokes this by choosing rate 3 with a tone-2 period of 1 and holding tick high. The counter then expires every cycle, and writes land on a dense schedule that is bound to hit shift cycles. After each such cycle the bench compares noiseOut with a cycle model built from the requirements. A wrong priority shows up as a changed output or a shifted sequence that drifts from the model.

// File: rtl/psg_noise_pkg.sv
package psg_noise_pkg;
  // Reload value for rate selector 0; selectors 1 and 2 double it each step.
  localparam int RATE_BASE = 16;

  typedef struct packed {
    logic shiftEn;   // step the register this cycle
    logic seedEn;    // reload the single-top-bit seed
    logic whiteMode; // feedback from tap parity instead of wrap-around
  } noiseStrobe_t;
endpackage

// File: rtl/psg_noise_ctrl.sv
module psg_noise_ctrl
  import psg_noise_pkg::*;
#(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          ctrlVal,
  input  logic                ctrlWr,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] tone2Period,
  output noiseStrobe_t        strobe,
  output logic                tglQ
);
  localparam int RATE_SEL_N = 3;

  logic [2:0]          ctrlReg;
  logic [PERIOD_W-1:0] cntQ;
  logic [PERIOD_W-1:0] cntDec;
  logic [PERIOD_W-1:0] reloadVal;
  logic [PERIOD_W-1:0] fixedRate [RATE_SEL_N];
  logic                expire;

  // Fixed reload values, one per selector code below 3.
  for (genvar g = 0; g < RATE_SEL_N; g++) begin : g_rate
    assign fixedRate[g] = PERIOD_W'(RATE_BASE << g);
  end

  always_comb begin
    if (ctrlReg[1:0] == 2'd3) reloadVal = tone2Period;
    else                      reloadVal = fixedRate[ctrlReg[1:0]];
  end

  assign cntDec = (cntQ == '0) ? '0 : cntQ - 1'b1;
  assign expire = tick && (cntDec == '0);

  always_comb begin
    strobe.shiftEn   = expire && !tglQ;
    strobe.seedEn    = ctrlWr;
    strobe.whiteMode = ctrlReg[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
      cntQ    <= '0;
      tglQ    <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= ctrlVal;
      if (tick)   cntQ    <= expire ? reloadVal : cntDec;
      if (expire) tglQ    <= ~tglQ;
    end
  end
endmodule

// File: rtl/psg_noise_dp.sv
module psg_noise_dp
  import psg_noise_pkg::*;
#(
  parameter int               LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = LFSR_W'(16'h0009)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  noiseStrobe_t      strobe,
  output logic [LFSR_W-1:0] lfsrQ,
  output logic              noiseOut
);
  localparam logic [LFSR_W-1:0] SEED = {1'b1, {(LFSR_W-1){1'b0}}};

  logic feedBit;

  assign feedBit = strobe.whiteMode ? ^(lfsrQ & TAP_MASK) : lfsrQ[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsrQ    <= SEED;
      noiseOut <= 1'b0;
    end else if (strobe.seedEn) begin
      lfsrQ    <= SEED;
    end else if (strobe.shiftEn) begin
      lfsrQ    <= {feedBit, lfsrQ[LFSR_W-1:1]};
      noiseOut <= lfsrQ[0];
    end
  end
endmodule

// File: rtl/psg_noise_chan.sv
module psg_noise_chan
  import psg_noise_pkg::*;
#(
  parameter int               PERIOD_W = 10,
  parameter int               LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = LFSR_W'(16'h0009)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          ctrlVal,
  input  logic                ctrlWr,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] tone2Period,
  output logic                noiseOut
);
  noiseStrobe_t      strobe;
  logic              tglQ;
  logic [LFSR_W-1:0] lfsrQ;
  logic              shiftEn;
  logic              whiteMode;

  assign shiftEn   = strobe.shiftEn;
  assign whiteMode = strobe.whiteMode;

  psg_noise_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrlVal(ctrlVal), .ctrlWr(ctrlWr),
    .tick(tick), .tone2Period(tone2Period), .strobe(strobe), .tglQ(tglQ)
  );

  psg_noise_dp #(.LFSR_W(LFSR_W), .TAP_MASK(TAP_MASK)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .lfsrQ(lfsrQ), .noiseOut(noiseOut)
  );
endmodule

// File: rtl/psg_noise_chk.sv
module psg_noise_chk #(
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrlWr,
  input logic              tick,
  input logic              shiftEn,
  input logic              whiteMode,
  input logic              tglQ,
  input logic [LFSR_W-1:0] lfsrQ,
  input logic              noiseOut
);
  localparam logic [LFSR_W-1:0] SEED = {1'b1, {(LFSR_W-1){1'b0}}};

  p_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWr |=> lfsrQ == SEED);

  p_shift_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shiftEn |=> tglQ);

  p_shift_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shiftEn |-> tick);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctrlWr) |=> ($stable(lfsrQ) && $stable(tglQ) && $stable(noiseOut)));

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(shiftEn && !ctrlWr) |=> $stable(noiseOut));

  p_out_shifted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shiftEn && !ctrlWr) |=> noiseOut == $past(lfsrQ[0]));

  p_rotate_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shiftEn && !ctrlWr && !whiteMode) |=> $countones(lfsrQ) == $past($countones(lfsrQ)));
endmodule

bind psg_noise_chan psg_noise_chk #(.LFSR_W(LFSR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ctrlWr(ctrlWr), .tick(tick), .shiftEn(shiftEn),
  .whiteMode(whiteMode), .tglQ(tglQ), .lfsrQ(lfsrQ), .noiseOut(noiseOut)
);

// File: tb/test_psg_noise_chan.sv
module test_psg_noise_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ctrlVal = '0;
  logic       ctrlWr = 1'b0;
  logic       tick = 1'b0;
  logic [9:0] tone2Period = 10'd5;
  logic       noiseOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements (16-bit, taps 0 and 3).
  logic [2:0]  mCtrl;
  int          mCnt;
  logic        mTgl;
  logic [15:0] mLfsr;
  logic        mOut;

  always #10 clk = ~clk; // 50 MHz

  psg_noise_chan i_psg_noise_chan (
    .clk(clk), .rst_n(rst_n), .ctrlVal(ctrlVal), .ctrlWr(ctrlWr),
    .tick(tick), .tone2Period(tone2Period), .noiseOut(noiseOut)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s noiseOut actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mCtrl = '0; mCnt = 0; mTgl = 1'b0; mLfsr = 16'h8000; mOut = 1'b0;
  endtask

  // Called at a negedge: drive, take the edge, update the model, compare.
  task automatic step(input string tag, input logic wr, input logic [2:0] val, input logic tk);
    int dec, rel;
    logic exp, shiftNow, fb;
    ctrlWr = wr; ctrlVal = val; tick = tk;
    @(posedge clk);
    dec = (mCnt == 0) ? 0 : mCnt - 1;
    exp = tk && (dec == 0);
    rel = (mCtrl[1:0] == 2'd3) ? int'(tone2Period) : (16 << mCtrl[1:0]);
    shiftNow = exp && !mTgl;
    if (wr) mLfsr = 16'h8000;
    else if (shiftNow) begin
      fb = mCtrl[2] ? (mLfsr[0] ^ mLfsr[3]) : mLfsr[0];
      mOut = mLfsr[0];
      mLfsr = {fb, mLfsr[15:1]};
    end
    if (tk) mCnt = exp ? rel : dec;
    if (exp) mTgl = ~mTgl;
    if (wr) mCtrl = val;
    @(negedge clk);
    check(tag, noiseOut, mOut);
  endtask

  task automatic run(input string tag, input int n, input logic tk);
    for (int i = 0; i < n; i++) step(tag, 1'b0, ctrlVal, tk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int edges;
    logic prev;
    modelReset();
    repeat (3) @(negedge clk);
    check("R1", noiseOut, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", noiseOut, 1'b0);
    // From reset: rotate mode at rate 16, the seed pulse must emerge on shift 16.
    run("R1", 1200, 1'b1);

    // Sweep every control value with a running tick.
    tone2Period = 10'd5;
    for (int v = 0; v < 8; v++) begin
      step("R2", 1'b1, 3'(v), 1'b1);
      if (v[2]) run("R6", 2200, 1'b1);
      else      run("R7", 2200, 1'b1);
    end

    // No tick, no write: everything holds.
    run("R3", 60, 1'b0);
    // Sparse ticks at rate 32, white mode.
    step("R4", 1'b1, 3'd5, 1'b0);
    for (int i = 0; i < 900; i++) step("R4", 1'b0, 3'd5, (i % 3) == 0);

    // Tone-2 following with degenerate periods.
    tone2Period = 10'd0;
    step("R10", 1'b1, 3'd3, 1'b1);
    run("R10", 200, 1'b1);
    tone2Period = 10'd1;
    step("R10", 1'b1, 3'd7, 1'b1);
    run("R10", 200, 1'b1);

    // Writes colliding with shifts: expiry on every tick.
    for (int i = 0; i < 400; i++)
      step("R8", (i % 3) == 1, (i % 2 == 0) ? 3'd7 : 3'd3, 1'b1);
    run("R8", 100, 1'b1);

    // Rate change mid-count keeps counter and half-period bit.
    tone2Period = 10'd9;
    step("R9", 1'b1, 3'd2, 1'b1);
    run("R9", 20, 1'b1);
    step("R9", 1'b1, 3'd0, 1'b1);
    run("R9", 300, 1'b1);
    step("R9", 1'b1, 3'd3, 1'b1);
    run("R9", 300, 1'b1);

    // Duty of rotate mode: one pulse per 16 shifts, 10 pulses in the window.
    step("R7", 1'b1, 3'd0, 1'b1);
    edges = 0;
    prev = noiseOut;
    for (int i = 0; i < 5200; i++) begin
      step("R7", 1'b0, 3'd0, 1'b1);
      if (noiseOut && !prev) edges++;
      prev = noiseOut;
    end
    checks++;
    if (edges != 10) begin
      failures++;
      $display("FAIL R7 pulse count actual=%0d expected=10", edges);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule